// File: doc/BRIEF.md
# Pseudorandom Test Word Source (9-stage and 23-stage)

This block produces one of two pseudorandom bit sequences, grouped into 12-bit words with the earliest bit in the most significant position. A capture stage on the receiving side can then compare its data against the same sequence bit by bit. The short sequence comes from a 9-stage shift-register recurrence and has a period of 511 bits. The long sequence comes from a 23-stage recurrence, has a period of 8,388,607 bits, and every output bit of it is inverted. Neither sequence starts from all ones. Each starts from its own fixed starting pattern, so the first words are known exactly.

Words leave the block on a valid/ready stream. A word is transferred on every clock edge at which `word_valid_o` and `word_ready_i` are both high, and the next word of the sequence then appears. While ready is low, the presented word holds unchanged. `word_valid_o` never depends on `word_ready_i`. A restart strobe, or a change of the sequence select, returns the selected sequence to its first word. The cycle in which that happens transfers nothing.

Top module: `pn_word_gen`

## Requirements
- R1: While `rst_n` is low, `word_valid_o` is 0. In the first cycle after reset is released, with the short sequence selected and no restart, `word_valid_o` is 1 and the word is the first short word.
- R2: With `seq_sel_i` = 0 (short sequence), the first three words after a (re)start are 0xDF9, 0x353 and 0x301.
- R3: With `seq_sel_i` = 1 (long sequence), the first three words after a (re)start are 0x591, 0xFD7 and 0x0A3.
- R4: Consecutive transferred words continue one bit stream without gaps. Short: x[n] = x[n-9] xor x[n-5]. Long: the same recurrence with taps 23 and 18, with each bit inverted at the output.
- R5: The short word sequence repeats after 511 transferred words: word 511 equals word 0 and word 512 equals word 1.
- R6: While `word_valid_o` is 1 and `word_ready_i` is 0, no word is consumed. The same word is presented again in the next cycle.
- R7: In a cycle with `restart_i` = 1, `word_valid_o` is 0 and nothing is transferred. The next word presented is the first word of the selected sequence.
- R8: In a cycle where `seq_sel_i` differs from its value in the previous cycle, `word_valid_o` is 0. The next word presented is the first word of the newly selected sequence.
- R9: Outside reset, restart and select-change cycles, `word_valid_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| seq_sel_i | input | 1 | 0 selects the 9-stage sequence, 1 the 23-stage sequence |
| restart_i | input | 1 | Returns the selected sequence to its first word |
| word_ready_i | input | 1 | Consumer accepts the presented word |
| word_valid_o | output | 1 | A word is presented |
| word_o | output | 12 | Presented word; the earliest bit is the MSB |

## Verification
The hardest condition to reach from the ports is the wrap of the short sequence. Only after 511 transferred words, or 6132 bits, does the first word come back. The stimulus drives the short stream through more than a full period, with ready low in every third cycle, so back-pressure and the wrap are exercised in the same run. A serial bit model in the bench predicts every word. The long sequence cannot be run through its full period, so it is instead interrupted mid-stream by a restart and by select changes in both directions. Each interruption must land exactly on that sequence's first word.

// File: rtl/pn_word_pkg.sv
package pn_word_pkg;

  localparam int unsigned WORD_W = 12;

  typedef enum logic {
    SEQ_SHORT = 1'b0,
    SEQ_LONG  = 1'b1
  } seq_e;

  localparam int unsigned        SHORT_LEN  = 9;
  localparam int unsigned        SHORT_TAP  = 5;
  localparam logic [SHORT_LEN-1:0] SHORT_SEED = 9'h0DF;

  localparam int unsigned        LONG_LEN  = 23;
  localparam int unsigned        LONG_TAP  = 18;
  localparam logic [LONG_LEN-1:0] LONG_SEED = 23'h29B80A;

endpackage

// File: rtl/pn_step_core.sv
// One shift-register recurrence x[n] = x[n-LEN] ^ x[n-TAP], advanced a whole
// word per step. The state holds the next LEN stream bits, oldest in the MSB.
module pn_step_core #(
  parameter int unsigned     LEN    = 9,
  parameter int unsigned     TAP    = 5,
  parameter logic [LEN-1:0]  SEED   = 9'h0DF,
  parameter bit              INVERT = 1'b0,
  parameter int unsigned     WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reload_i,
  input  logic              step_i,
  output logic [WORD_W-1:0] word_o
);

  localparam int unsigned EXT_W = WORD_W + LEN;
  // the stream begins one bit after the seed pattern
  localparam logic [LEN-1:0] START = {SEED[LEN-2:0], SEED[LEN-1] ^ SEED[TAP-1]};

  logic [LEN-1:0] state_q;
  logic [LEN-1:0] state_nxt;
  logic [EXT_W-1:0] ext;

  function automatic logic [EXT_W-1:0] unroll(input logic [LEN-1:0] s);
    logic [EXT_W-1:0] e;
    e = '0;
    for (int j = 0; j < int'(LEN); j++) e[j] = s[LEN-1-j];
    for (int j = int'(LEN); j < int'(EXT_W); j++) e[j] = e[j-int'(LEN)] ^ e[j-int'(TAP)];
    return e;
  endfunction

  always_comb begin
    ext = unroll(state_q);
    for (int i = 0; i < int'(WORD_W); i++) word_o[WORD_W-1-i] = ext[i] ^ INVERT;
    for (int j = 0; j < int'(LEN); j++) state_nxt[LEN-1-j] = ext[WORD_W+j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        state_q <= START;
    else if (reload_i) state_q <= START;
    else if (step_i)   state_q <= state_nxt;
  end

  // R4
  state_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);

  // R7
  reload_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> state_q == START);

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!reload_i && !step_i) |=> $stable(state_q));

endmodule

// File: rtl/pn_seq_ctrl.sv
module pn_seq_ctrl
  import pn_word_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  seq_e       sel_i,
  input  logic       restart_i,
  input  logic       ready_i,
  output seq_e       sel_q_o,
  output logic       valid_o,
  output logic [1:0] reload_o,
  output logic [1:0] step_o
);

  seq_e sel_q;
  logic run_q;
  logic changed;
  logic hs;

  assign changed = (sel_i != sel_q);
  assign valid_o = run_q && !restart_i && !changed;
  assign hs      = valid_o && ready_i;
  assign sel_q_o = sel_q;

  for (genvar k = 0; k < 2; k++) begin : g_lane
    assign reload_o[k] = (restart_i || changed) && (sel_i == seq_e'(k));
    assign step_o[k]   = hs && (sel_q == seq_e'(k));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= SEQ_SHORT;
      run_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      run_q <= 1'b1;
    end
  end

  // R7
  restart_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |-> !valid_o);

  // R8
  switch_reloads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i != sel_q) |-> (!valid_o && $countones(reload_o) == 1));

  // R4
  one_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(step_o));

endmodule

// File: rtl/pn_word_gen.sv
module pn_word_gen
  import pn_word_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_sel_i,
  input  logic              restart_i,
  input  logic              word_ready_i,
  output logic              word_valid_o,
  output logic [WORD_W-1:0] word_o
);

  seq_e              sel_q;
  logic [1:0]        reload;
  logic [1:0]        step;
  logic [WORD_W-1:0] w_short;
  logic [WORD_W-1:0] w_long;

  pn_seq_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel_i     (seq_e'(seq_sel_i)),
    .restart_i (restart_i),
    .ready_i   (word_ready_i),
    .sel_q_o   (sel_q),
    .valid_o   (word_valid_o),
    .reload_o  (reload),
    .step_o    (step)
  );

  pn_step_core #(
    .LEN(SHORT_LEN), .TAP(SHORT_TAP), .SEED(SHORT_SEED),
    .INVERT(1'b0), .WORD_W(WORD_W)
  ) u_short (
    .clk(clk), .rst_n(rst_n), .reload_i(reload[0]), .step_i(step[0]), .word_o(w_short)
  );

  pn_step_core #(
    .LEN(LONG_LEN), .TAP(LONG_TAP), .SEED(LONG_SEED),
    .INVERT(1'b1), .WORD_W(WORD_W)
  ) u_long (
    .clk(clk), .rst_n(rst_n), .reload_i(reload[1]), .step_i(step[1]), .word_o(w_long)
  );

  assign word_o = (sel_q == SEQ_LONG) ? w_long : w_short;

  // R6
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid_o && !word_ready_i) |=> $stable(word_o));

  // R9
  valid_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!restart_i && seq_sel_i == $past(seq_sel_i) && $past(rst_n)) |-> word_valid_o);

endmodule

// File: tb/test_pn_word_gen.sv
module test_pn_word_gen;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0;
  logic        restart = 1'b0;
  logic        ready = 1'b0;
  logic        valid;
  logic [11:0] word;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [8:0]  m_s;
  logic [22:0] m_l;

  always #(CLK_PERIOD/2) clk = ~clk;

  pn_word_gen i_pn_word_gen (
    .clk(clk), .rst_n(rst_n), .seq_sel_i(sel), .restart_i(restart),
    .word_ready_i(ready), .word_valid_o(valid), .word_o(word)
  );

  task automatic chk(input string req, input logic [22:0] act, input logic [22:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // serial model: window holds the next N bits, oldest in the MSB
  function automatic logic [8:0] s_shift(input logic [8:0] w);
    return {w[7:0], w[8] ^ w[4]};
  endfunction
  function automatic logic [22:0] l_shift(input logic [22:0] w);
    return {w[21:0], w[22] ^ w[17]};
  endfunction

  task automatic model_init(input logic which);
    if (!which) m_s = s_shift(9'h0DF);
    else        m_l = l_shift(23'h29B80A);
  endtask

  function automatic logic [11:0] model_word(input logic which);
    logic [11:0] r;
    logic [8:0]  ws;
    logic [22:0] wl;
    ws = m_s; wl = m_l;
    for (int i = 0; i < 12; i++) begin
      if (!which) begin r = {r[10:0], ws[8]};  ws = s_shift(ws); end
      else        begin r = {r[10:0], ~wl[22]}; wl = l_shift(wl); end
    end
    return r;
  endfunction

  task automatic model_adv(input logic which);
    for (int i = 0; i < 12; i++) begin
      if (!which) m_s = s_shift(m_s);
      else        m_l = l_shift(m_l);
    end
  endtask

  task automatic drive(input logic s, input logic r, input logic rd);
    @(negedge clk);
    sel = s; restart = r; ready = rd;
    #1;
  endtask

  task automatic summary;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int hs;
    logic prev_rd;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 valid in reset", valid, 0);
    rst_n = 1'b1;
    model_init(0);
    model_init(1);

    drive(0, 0, 0);
    chk("R1 valid after reset", valid, 1);
    chk("R1 first word", word, 12'hDF9);

    // short stream across a full period with back-pressure
    hs = 0; prev_rd = 1;
    for (int c = 0; hs < 514; c++) begin
      logic rd;
      rd = (c % 3) != 2;
      drive(0, 0, rd);
      chk("R9 valid", valid, 1);
      if (!prev_rd) chk("R6 held word", word, model_word(0));
      else          chk("R4 short word", word, model_word(0));
      if (hs == 0) chk("R2 word0", word, 12'hDF9);
      if (hs == 1) chk("R2 word1", word, 12'h353);
      if (hs == 2) chk("R2 word2", word, 12'h301);
      if (hs == 511) chk("R5 wrap word0", word, 12'hDF9);
      if (hs == 512) chk("R5 wrap word1", word, 12'h353);
      if (rd) begin model_adv(0); hs++; end
      prev_rd = rd;
    end

    // switch to long
    drive(1, 0, 1);
    chk("R8 valid on switch", valid, 0);
    model_init(1);
    hs = 0;
    for (int c = 0; hs < 300; c++) begin
      logic rd;
      rd = (c % 4) != 3;
      drive(1, 0, rd);
      chk("R9 valid", valid, 1);
      chk("R4 long word", word, model_word(1));
      if (hs == 0) chk("R3 word0", word, 12'h591);
      if (hs == 1) chk("R3 word1", word, 12'hFD7);
      if (hs == 2) chk("R3 word2", word, 12'h0A3);
      if (rd) begin model_adv(1); hs++; end
    end

    // restart mid-stream
    drive(1, 1, 1);
    chk("R7 valid on restart", valid, 0);
    drive(1, 0, 1);
    chk("R7 first word after restart", word, 12'h591);
    drive(1, 0, 1);
    chk("R7 second word after restart", word, 12'hFD7);

    // back to short, whose core was mid-stream
    drive(0, 0, 1);
    chk("R8 valid on switch back", valid, 0);
    drive(0, 0, 1);
    chk("R8 short restarts", word, 12'hDF9);
    drive(0, 0, 1);
    chk("R8 short second", word, 12'h353);

    done = 1;
    summary();
    $finish;
  end

endmodule